// File: doc/BRIEF.md
# Serial Presence-Detect Configuration EEPROM (Two-Wire Slave)

This block models a 256-byte configuration memory reached over a two-wire I2C bus. It samples SCL and SDA with the system clock, recognises START and STOP conditions, and answers to a 7-bit device address. The upper four address bits are fixed at 1010b and three strap inputs supply the low three bits. SDA is open-drain: the block only ever pulls the line low through `sda_oe`, and an external pull-up supplies the high level.

A master sets a one-byte word-address pointer with a write transfer. It then either writes data bytes at the pointer or, after a repeated START, reads bytes from it. The pointer steps after every data byte in either direction and wraps from 255 to 0. The memory starts from a parameter image. With checksum generation enabled, byte 63 is replaced at start-up by the low eight bits of the sum of bytes 0 to 62.

A lock input protects the lower half of the array. Once it has been seen high, writes to bytes 0 to 127 are still acknowledged but leave the stored data unchanged, until the next reset. Bytes 128 to 255 stay writable.

Top module: `spd_eeprom`

## Requirements
- R1: After synchronous reset, `sda_oe` is low, so the block does not drive the bus.
- R2: The first byte after START carries the 7-bit address MSB first, then the direction bit (0 = write, 1 = read). The block pulls SDA low in the acknowledge slot only when the address equals {1010b, strap_i[2:0]}. On a mismatch it leaves SDA released until the next START, and the pointer and memory are unchanged.
- R3: In a write transfer, the byte after the address sets the word pointer. Each later byte is stored at the pointer, and every byte is acknowledged.
- R4: A read transfer returns the byte at the current pointer. This holds whether the pointer was just set by a write transfer ended with a repeated START, or was left by an earlier transfer.
- R5: During a read, the pointer steps after each byte. A master acknowledge (SDA low) makes the next byte follow. A master no-acknowledge releases SDA and ends the read, and the block then waits for STOP or START.
- R6: The pointer wraps from 255 to 0, for reads and for writes.
- R7: Once `lock_i` has been high for a clock, writes to addresses 0 to 127 are acknowledged but do not change the memory, until reset. Addresses 128 to 255 stay writable.
- R8: The initial contents come from the INIT parameter, with byte i in INIT[8i+7:8i]. The default image reads 0x80 at byte 0 and 0x08 at byte 1. With CSUM_EN set, byte 63 holds the low 8 bits of the sum of bytes 0 to 62 (0x88 for the default image).
- R9: Data is MSB first. The block changes `sda_oe` only after an SCL falling edge, or at START or STOP. It holds `sda_oe` low during every bit the master owns: address bits, written data and the master acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when high (open-drain driver enable) |
| strap_i | input | 3 | Low three bits of the device address |
| lock_i | input | 1 | Sticky write protect for the lower half |

## Verification
On every cycle, the assertions check three things. The SDA driver moves only after an SCL fall or a bus condition. The block stays silent while idle or ignoring a foreign address. The pointer wraps to zero. A further assertion checks that no write reaches the lower half once the lock has been seen. The bench's reference model compares the wire against the expected owner and bit in every high SCL phase. Only its scenarios can show the following: the stored contents and the checksum byte, random versus current-address reads, sequential reads across the wrap, acknowledged-but-dropped locked writes, and that a mismatched address leaves the pointer untouched.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } xfer_st_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/spd_xfer_fsm.sv
module spd_xfer_fsm
  import spd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [SW-1:0] strap,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);
  localparam logic [AW-1:0] PTR_MAX = '1;

  xfer_st_t      state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, txreg;
  logic [AW-1:0] ptr_q;
  logic          rw_q, mack_q, sda_oe_q, ptr_step;

  assign ptr_step = !start_p && !stop_p && scl_fall &&
                    ((state == ST_WDAT && cnt == LAST) ||
                     (state == ST_DEV_ACK && rw_q) ||
                     (state == ST_RACK && mack_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_req <= 1'b0;
      if (ptr_step) ptr_q <= ptr_q + 1'b1;
      if (start_p) begin
        state    <= ST_DEV;
        cnt      <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_p) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_oe_q <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          ST_DEV, ST_WADR, ST_WDAT: begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end
          ST_RDAT: cnt <= cnt + 1'b1;
          ST_RACK: mack_q <= !sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          ST_DEV: if (cnt == LAST) begin
            cnt <= '0;
            if (shreg[DW-1:1] == {DEV_TYPE, strap}) begin
              rw_q     <= shreg[0];
              sda_oe_q <= 1'b1;
              state    <= ST_DEV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_WADR: if (cnt == LAST) begin
            cnt      <= '0;
            ptr_q    <= shreg[AW-1:0];
            sda_oe_q <= 1'b1;
            state    <= ST_WADR_ACK;
          end
          ST_WDAT: if (cnt == LAST) begin
            cnt      <= '0;
            wr_req   <= 1'b1;
            wr_addr  <= ptr_q;
            wr_data  <= shreg;
            sda_oe_q <= 1'b1;
            state    <= ST_WDAT_ACK;
          end
          ST_DEV_ACK: begin
            if (rw_q) begin
              txreg    <= rd_data;
              sda_oe_q <= !rd_data[DW-1];
              state    <= ST_RDAT;
            end else begin
              sda_oe_q <= 1'b0;
              state    <= ST_WADR;
            end
          end
          ST_WADR_ACK, ST_WDAT_ACK: begin
            sda_oe_q <= 1'b0;
            state    <= ST_WDAT;
          end
          ST_RDAT: begin
            if (cnt == LAST) begin
              cnt      <= '0;
              sda_oe_q <= 1'b0;
              state    <= ST_RACK;
            end else begin
              txreg    <= {txreg[DW-2:0], 1'b0};
              sda_oe_q <= !txreg[DW-2];
            end
          end
          ST_RACK: begin
            if (mack_q) begin
              txreg    <= rd_data;
              sda_oe_q <= !rd_data[DW-1];
              state    <= ST_RDAT;
            end else begin
              sda_oe_q <= 1'b0;
              state    <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = ptr_q;
  assign sda_oe  = sda_oe_q;

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_q != $past(sda_oe_q)) |-> $past(scl_fall || start_p || stop_p));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe_q);

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_step && ptr_q == PTR_MAX) |=> (ptr_q == '0));
endmodule

// File: rtl/spd_wr_guard.sv
module spd_wr_guard #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int LOCK_BOUND = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_i,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  localparam logic [AW:0] BOUND_V = (AW+1)'(LOCK_BOUND);

  logic lock_q, in_low;

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_q | lock_i;
  end

  assign in_low   = ({1'b0, req_addr} < BOUND_V);
  assign mem_we   = req_we && !(lock_q && in_low);
  assign mem_addr = req_addr;
  assign mem_data = req_data;
endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [DW*(2**AW)-1:0] INIT = {{(DW*(2**AW)-16){1'b0}}, 8'h08, 8'h80},
  parameter bit CSUM_EN = 1'b1,
  parameter int CSUM_LAST = 62
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2**AW;

  function automatic logic [DW-1:0] image_sum();
    logic [DW-1:0] s;
    s = '0;
    for (int i = 0; i <= CSUM_LAST; i++) s = s + INIT[i*DW +: DW];
    return s;
  endfunction

  localparam logic [DW-1:0] CSUM_V = image_sum();

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*DW +: DW];
    if (CSUM_EN) mem[CSUM_LAST+1] = CSUM_V;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int SYNC       = 2,
  parameter int LOCK_BOUND = 128,
  parameter logic [DW*(2**AW)-1:0] INIT = {{(DW*(2**AW)-16){1'b0}}, 8'h08, 8'h80},
  parameter bit CSUM_EN    = 1'b1,
  parameter int CSUM_LAST  = 62
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       lock_i
);
  localparam logic [AW:0] BOUND_V = (AW+1)'(LOCK_BOUND);

  logic          sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [DW-1:0] rd_data, req_data, mem_data;
  logic [AW-1:0] rd_addr, req_addr, mem_addr;
  logic          req_we, mem_we;

  spd_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  spd_xfer_fsm #(.AW(AW), .DW(DW), .SW(3)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .strap(strap_i), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_req(req_we), .wr_addr(req_addr), .wr_data(req_data),
    .sda_oe(sda_oe)
  );

  spd_wr_guard #(.AW(AW), .DW(DW), .LOCK_BOUND(LOCK_BOUND)) u_guard (
    .clk(clk), .rst(rst), .lock_i(lock_i), .req_we(req_we),
    .req_addr(req_addr), .req_data(req_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  spd_mem #(.AW(AW), .DW(DW), .INIT(INIT), .CSUM_EN(CSUM_EN),
            .CSUM_LAST(CSUM_LAST)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R7
  lock_block_chk: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> !(mem_we && ({1'b0, mem_addr} < BOUND_V)));
endmodule

// File: tb/sim_spd_eeprom.sv
module sim_spd_eeprom;
  localparam int H = 10;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic lock = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = !(m_low | sda_oe);

  always #4 clk = ~clk;

  spd_eeprom u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .lock_i(lock)
  );

  // reference model
  logic [7:0] ref_mem [256];
  int ref_ptr = 0;
  bit ref_lock = 1'b0;
  logic [7:0] wq [$];

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  bit exp_own = 1'b0, exp_bit = 1'b0, done = 1'b0;
  int hi_cnt = 0;

  // every-clock bus-ownership monitor (R9)
  always @(negedge clk) begin
    if (rst || !scl_m) hi_cnt = 0;
    else hi_cnt = hi_cnt + 1;
    if (hi_cnt == 6) begin
      mon_chk = mon_chk + 1;
      if (sda_oe !== (exp_own ? !exp_bit : 1'b0)) begin
        mon_fail = mon_fail + 1;
        $display("FAIL R9 drive act=%0b exp=%0b t=%0t", sda_oe,
                 exp_own ? !exp_bit : 1'b0, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    exp_own = 1'b0;
    m_low = 1'b0; wait_h();
    scl_m = 1'b1; wait_h();
    m_low = 1'b1; wait_h();
    scl_m = 1'b0; wait_h();
  endtask

  task automatic i2c_stop();
    exp_own = 1'b0;
    m_low = 1'b1; wait_h();
    scl_m = 1'b1; wait_h();
    m_low = 1'b0; wait_h();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      exp_own = 1'b0;
      m_low = !b[i]; wait_h();
      scl_m = 1'b1; wait_h();
      scl_m = 1'b0;
    end
    m_low = 1'b0;
    exp_own = exp_ack; exp_bit = 1'b0;
    wait_h();
    scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    acked = !sda_line;
    repeat (H - H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit give_ack, output logic [7:0] got);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      exp_own = 1'b1; exp_bit = exp[i];
      wait_h();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      got[i] = sda_line;
      repeat (H - H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    exp_own = 1'b0;
    wait_h();
    m_low = give_ack;
    wait_h();
    scl_m = 1'b1; wait_h();
    scl_m = 1'b0;
    if (!give_ack) m_low = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] a, input string tag);
    bit ak;
    i2c_start();
    send_byte(DEV_W, 1'b1, ak);
    chk(ak, {tag, " dev-w ack"}, ak, 1);
    send_byte(a, 1'b1, ak);
    chk(ak, {tag, " word-addr ack"}, ak, 1);
    ref_ptr = a;
  endtask

  task automatic do_write(input logic [7:0] a, input string tag);
    bit ak;
    set_ptr(a, tag);
    foreach (wq[k]) begin
      send_byte(wq[k], 1'b1, ak);
      chk(ak, {tag, " data ack"}, ak, 1);
      if (!(ref_lock && ref_ptr < 128)) ref_mem[ref_ptr] = wq[k];
      ref_ptr = (ref_ptr + 1) % 256;
    end
    i2c_stop();
    wq.delete();
  endtask

  task automatic do_read(input int n, input string tag);
    bit ak;
    logic [7:0] got, exp;
    i2c_start();
    send_byte(DEV_R, 1'b1, ak);
    chk(ak, {tag, " dev-r ack"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      exp = ref_mem[ref_ptr];
      recv_byte(exp, i < n - 1, got);
      chk(got === exp, {tag, " read data"}, got, exp);
      ref_ptr = (ref_ptr + 1) % 256;
    end
    i2c_stop();
  endtask

  initial begin
    bit ak;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    ref_mem[0] = 8'h80; ref_mem[1] = 8'h08; ref_mem[63] = 8'h88;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sda_oe === 1'b0, "R1 reset sda_oe", sda_oe, 0);

    // R8 initial image and R4 random read
    set_ptr(8'd0, "R4");
    do_read(3, "R8 image R4");
    set_ptr(8'd62, "R8");
    do_read(2, "R8 checksum");

    // R3 writes, read back
    wq.push_back(8'h77); wq.push_back(8'h78);
    do_write(8'd64, "R3");
    set_ptr(8'd64, "R3");
    do_read(2, "R3 readback");

    // R2 foreign address ignored, pointer kept (R4 current address read)
    set_ptr(8'd64, "R2 setup");
    i2c_stop();
    i2c_start();
    send_byte(8'hA2, 1'b0, ak);
    chk(!ak, "R2 foreign address nack", ak, 0);
    send_byte(8'h10, 1'b0, ak);
    chk(!ak, "R2 foreign data nack", ak, 0);
    i2c_stop();
    do_read(1, "R2 R4 current-address");

    // R6 wrap on write and on read
    wq.push_back(8'h11); wq.push_back(8'h22);
    do_write(8'd255, "R6 write");
    set_ptr(8'd254, "R6");
    do_read(4, "R6 wrap read");

    // R7 sticky lock
    lock = 1'b1; repeat (2) @(negedge clk);
    lock = 1'b0; ref_lock = 1'b1;
    wq.push_back(8'h33);
    do_write(8'd20, "R7 low");
    set_ptr(8'd20, "R7");
    do_read(1, "R7 low unchanged");
    wq.push_back(8'h44); wq.push_back(8'h55);
    do_write(8'd127, "R7 edge");
    set_ptr(8'd127, "R7");
    do_read(2, "R7 edge readback");
    wq.push_back(8'h66); wq.push_back(8'h99);
    do_write(8'd255, "R7 R6 wrap");
    set_ptr(8'd255, "R7");
    do_read(2, "R7 R6 wrap readback");

    // R5 long sequential read with NACK end
    set_ptr(8'd60, "R5");
    do_read(8, "R5 sequential");
    repeat (2 * H) @(negedge clk);
    chk(sda_oe === 1'b0, "R5 released after nack", sda_oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end
endmodule